// File: doc/BRIEF.md
# Sample Read Rate Pacer

This block sits between an audio sample source that produces words whenever it likes and a consumer that reads them over a ready/valid stream. It keeps only the newest 24-bit signed sample from the source. It offers that sample downstream no more often than a fixed rate, 20000 words per second by default. The rate is derived from the system clock frequency, which is a parameter.

The minimum spacing is counted from the last completed transfer, not from a free-running tick. A consumer that raises its ready signal early is held off until the spacing has elapsed. Source words that arrive while the spacing runs replace one another, and only the last one is sent. A captured word is sent at most once. If nothing new has arrived, nothing is offered.

Top module: `sample_rate_pacer`

## Requirements
- R1: After reset `m_tvalid` is low, and it stays low for as long as no source word has been captured.
- R2: Let INTERVAL be CLK_HZ/RATE_HZ, which is 5000 cycles at 100 MHz. Two accepted transfers (`m_tvalid` and `m_tready` both high at a rising edge) are always at least INTERVAL edges apart. If the consumer holds `m_tready` high and a fresh word is waiting, the next transfer happens exactly INTERVAL edges after the previous one, and `m_tvalid` rises one edge before that.
- R3: After reset, with no transfer yet, a word presented with `src_valid` high in the cycle before edge E is captured at E. `m_tvalid` then rises at edge E+1.
- R4: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata` does not change, even if new source words arrive.
- R5: `m_tvalid` falls on the edge of an accepted transfer. Each captured word is offered at most once, so without a new source word `m_tvalid` stays low indefinitely.
- R6: The word offered is the most recent source word captured before `m_tvalid` rises. Words captured earlier in the same interval are discarded.
- R7: `m_tdata` carries the captured source word bit for bit as a two's-complement value, with its sign bit in bit DATA_W-1 (24'h800000 stays 24'h800000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source word strobe, one cycle per word, no back-pressure |
| src_data | input | DATA_W | Signed source word |
| m_tvalid | output | 1 | Output word available |
| m_tready | input | 1 | Consumer accepts the word |
| m_tdata | output | DATA_W | Signed output word |

## Verification
If the spacing counter is corrupted, the gap between two accepted transfers changes, and the change shows at the first transfer after the fault. The bench measures that gap to the exact cycle, so a reload that is off by one also shows. A wrong freshness flag shows up in one of two ways within one interval: a word is offered twice, or a word that was captured is never offered. A capture register that overwrites at the wrong time delivers a word other than the newest one, and the scoreboard catches that at the very next transfer.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    // Output stage state: whether a word is currently offered downstream.
    typedef enum logic {
        OFFER_IDLE = 1'b0,
        OFFER_BUSY = 1'b1
    } offer_state_e;

    // Number of clock cycles per output word at the requested rate.
    function automatic int unsigned interval_cycles(input int unsigned clk_hz,
                                                    input int unsigned rate_hz);
        return clk_hz / rate_hz;
    endfunction

    // Counter width able to hold values up to (cycles - 2); at least one bit.
    function automatic int unsigned timer_width(input int unsigned cycles);
        return (cycles > 2) ? $clog2(cycles) : 1;
    endfunction

endpackage

// File: rtl/pacer_sample_latch.sv
module pacer_sample_latch #(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              take,
    output logic [DATA_W-1:0] word,
    output logic              fresh
);

    // Newest source word wins. A word is marked fresh until it is taken.
    // If a new word arrives in the same cycle as a take, it stays fresh.
    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            fresh <= 1'b0;
        end else begin
            if (src_valid) begin
                word <= src_data;
            end
            if (src_valid) begin
                fresh <= 1'b1;
            end else if (take) begin
                fresh <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pacer_interval_timer.sv
module pacer_interval_timer
    import pacer_pkg::*;
#(
    parameter int unsigned INTERVAL = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);

    localparam int unsigned CNT_W = timer_width(INTERVAL);

    generate
        if (INTERVAL < 2) begin : g_free
            // Spacing of one cycle or less: no spacing is enforced.
            logic unused_inputs;
            assign unused_inputs = clk ^ rst ^ restart;
            assign expired = 1'b1;
        end else begin : g_count
            // Reload with INTERVAL-2. The output stage raises valid when the count
            // reaches zero, and the handshake lands on the following edge, so two
            // transfers end up exactly INTERVAL edges apart.
            localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 2);
            logic [CNT_W-1:0] remain_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    remain_q <= '0;
                end else if (restart) begin
                    remain_q <= RELOAD;
                end else if (remain_q != '0) begin
                    remain_q <= remain_q - 1'b1;
                end
            end

            assign expired = (remain_q == '0);
        end
    endgenerate

endmodule

// File: rtl/pacer_out_stage.sv
module pacer_out_stage
    import pacer_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              can_load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              m_tready,
    output logic              m_tvalid,
    output logic [DATA_W-1:0] m_tdata,
    output logic              load,
    output logic              xfer
);

    offer_state_e     state_q;
    logic [DATA_W-1:0] data_q;

    assign load = (state_q == OFFER_IDLE) && can_load;
    assign xfer = (state_q == OFFER_BUSY) && m_tready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OFFER_IDLE;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                OFFER_IDLE: begin
                    if (can_load) begin
                        state_q <= OFFER_BUSY;
                        data_q  <= load_word;
                    end
                end
                OFFER_BUSY: begin
                    // The data register stays frozen until the word is accepted.
                    if (m_tready) begin
                        state_q <= OFFER_IDLE;
                    end
                end
                default: state_q <= OFFER_IDLE;
            endcase
        end
    end

    assign m_tvalid = (state_q == OFFER_BUSY);
    assign m_tdata  = data_q;

endmodule

// File: rtl/sample_rate_pacer.sv
module sample_rate_pacer
    import pacer_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned RATE_HZ = 20_000,
    parameter int unsigned DATA_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata
);

    localparam int unsigned INTERVAL = interval_cycles(CLK_HZ, RATE_HZ);

    logic [DATA_W-1:0] held_word;
    logic              held_fresh;
    logic              gap_done;
    logic              load;
    logic              xfer;

    pacer_sample_latch #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .src_valid (src_valid),
        .src_data  (src_data),
        .take      (load),
        .word      (held_word),
        .fresh     (held_fresh)
    );

    pacer_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (xfer),
        .expired (gap_done)
    );

    pacer_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .can_load  (gap_done && held_fresh),
        .load_word (held_word),
        .m_tready  (m_tready),
        .m_tvalid  (m_tvalid),
        .m_tdata   (m_tdata),
        .load      (load),
        .xfer      (xfer)
    );

endmodule

// File: rtl/pacer_checker.sv
module pacer_checker
    import pacer_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned RATE_HZ = 20_000,
    parameter int unsigned DATA_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              src_valid,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata
);

    localparam int unsigned INTERVAL = interval_cycles(CLK_HZ, RATE_HZ);

    logic        seen_src;
    logic        seen_xfer;
    logic [31:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_src  <= 1'b0;
            seen_xfer <= 1'b0;
            gap_cnt   <= '0;
        end else begin
            if (src_valid) seen_src <= 1'b1;
            if (m_tvalid && m_tready) begin
                seen_xfer <= 1'b1;
                gap_cnt   <= 32'd1;
            end else if (gap_cnt != 32'hFFFF_FFFF) begin
                gap_cnt <= gap_cnt + 32'd1;
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata))); // R4

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && seen_xfer) |-> (gap_cnt >= INTERVAL)); // R2

    AST_OFFER_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> seen_src); // R3

    AST_DROP_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready) |=> !m_tvalid); // R5

endmodule

bind sample_rate_pacer pacer_checker #(
    .CLK_HZ  (CLK_HZ),
    .RATE_HZ (RATE_HZ),
    .DATA_W  (DATA_W)
) u_pacer_checker (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .m_tvalid  (m_tvalid),
    .m_tready  (m_tready),
    .m_tdata   (m_tdata)
);

// File: tb/tb_sample_rate_pacer.sv
module tb_sample_rate_pacer;

    localparam int DW  = 24;
    localparam int GAP = 5000;  // 100 MHz / 20 kHz

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          m_tready = 1'b0;
    logic          m_tvalid;
    logic [DW-1:0] m_tdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int hs_count = 0;
    int last_hs = 0;
    bit exact_gap = 1'b0;
    logic [DW-1:0] exp_q[$];

    sample_rate_pacer dut (
        .clk       (clk),
        .rst       (rst),
        .src_valid (src_valid),
        .src_data  (src_data),
        .m_tvalid  (m_tvalid),
        .m_tready  (m_tready),
        .m_tdata   (m_tdata)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Driver: one source word for one cycle; optionally push it as expected output.
    task automatic push_sample(input logic [DW-1:0] v, input bit expect_it);
        src_valid = 1'b1;
        src_data  = v;
        if (expect_it) exp_q.push_back(v);
        tick();
        src_valid = 1'b0;
    endtask

    // Monitor: at the falling edge, a valid&ready pair means a transfer at the next rising edge.
    always @(negedge clk) begin
        if (!rst && m_tvalid && m_tready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected transfer", int'(m_tdata), 0);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(m_tdata == e, "R6/R7 transfer data", int'(m_tdata), int'(e));
            end
            if (hs_count > 0) begin
                if (exact_gap)
                    check((cyc + 1 - last_hs) == GAP, "R2 exact gap", cyc + 1 - last_hs, GAP);
                else
                    check((cyc + 1 - last_hs) >= GAP, "R2 minimum gap", cyc + 1 - last_hs, GAP);
            end
            last_hs = cyc + 1;
            hs_count++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        check(m_tvalid == 1'b0, "R1 idle after reset", int'(m_tvalid), 0);
        repeat (10) tick();
        check(m_tvalid == 1'b0, "R1 idle without source word", int'(m_tvalid), 0);

        // R3 / R7: first word, negative full-scale value.
        push_sample(24'h800000, 1'b1);
        check(m_tvalid == 1'b0, "R3 not valid at capture edge", int'(m_tvalid), 0);
        tick();
        check(m_tvalid == 1'b1, "R3 valid one edge after capture", int'(m_tvalid), 1);
        check(m_tdata == 24'h800000, "R7 sign bit preserved", int'(m_tdata), 24'h800000);

        // R4: hold while not ready, even when a new word arrives.
        push_sample(24'h123456, 1'b0);
        repeat (20) tick();
        check(m_tvalid == 1'b1, "R4 valid held", int'(m_tvalid), 1);
        check(m_tdata == 24'h800000, "R4 data frozen", int'(m_tdata), 24'h800000);

        // Accept: transfer at edge H.
        m_tready = 1'b1;
        tick();
        m_tready = 1'b0;
        check(m_tvalid == 1'b0, "R5 valid drops after transfer", int'(m_tvalid), 0);

        // R6: newer words overwrite during the interval. R2: early ready is stalled.
        repeat (100) tick();
        push_sample(24'h00ABCD, 1'b0);
        repeat (100) tick();
        push_sample(24'h7FFFFF, 1'b1);
        m_tready = 1'b1;
        repeat (GAP - 2 - 202) tick();
        check(m_tvalid == 1'b0, "R2 stalled before interval ends", int'(m_tvalid), 0);
        tick();
        check(m_tvalid == 1'b1, "R2 valid one edge before interval ends", int'(m_tvalid), 1);
        check(m_tdata == 24'h7FFFFF, "R6 newest word offered", int'(m_tdata), 24'h7FFFFF);
        tick();
        check(m_tvalid == 1'b0, "R5 drop after stalled transfer", int'(m_tvalid), 0);

        // R5: no new word, nothing offered again.
        repeat (2 * GAP) tick();
        check(m_tvalid == 1'b0, "R5 no repeat without new word", int'(m_tvalid), 0);

        // R2: streaming with ready held high, one word per interval.
        for (int r = 0; r < 5; r++) begin
            int n;
            n = hs_count;
            push_sample(24'hFFFFF0 - 24'(r * 3), 1'b1);
            while (hs_count == n) tick();
            exact_gap = 1'b1;
            repeat (50) tick();
        end
        m_tready = 1'b0;
        repeat (5) tick();

        check(exp_q.size() == 0, "R6 all expected words delivered", exp_q.size(), 0);
        check(hs_count == 7, "R5 one transfer per fresh word", hs_count, 7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule